// File: doc/BRIEF.md
# E3 G.832 Transmit Overhead Generator with Error Injection

This block produces the byte stream of an E3 transmit frame in the G.832 arrangement, one byte per clock. It counts positions within a 537-byte frame. The first seven positions carry overhead bytes, and the remaining 530 positions carry payload bytes, which it pulls from a byte-wide payload input. The block builds the two alignment bytes, a BIP-8 parity byte computed over the whole previous frame, and the maintenance byte. The maintenance byte holds the remote defect and remote error indications. The other overhead bytes come from static register inputs and pass through unchanged.

For test, the block accepts single-shot requests that corrupt exactly one overhead bit in the next frame. The target can be the alignment pattern, the parity byte, the defect bit or the error-indication bit. A request takes effect only when the targeted field is produced internally. When a field's source is set to external, the field carries the external value, and a pending request for that field is discarded. Each applied error is reported by a strobe that is aligned with the corrupted byte.

Top module: `e3oh_gen`

## Requirements
- R1: A frame is 537 output bytes. `tx_sof` is high with the first byte and then every 537 cycles. The byte order is alignment byte 1 (0xF6), alignment byte 2 (0x28), parity, `tr_byte`, maintenance, `nr_byte`, `gc_byte`, and then 530 payload bytes.
- R2: `pl_ready` is high in exactly the cycles that form payload positions 7 to 536. The `pl_data` sampled in such a cycle appears on `tx_byte` in the next cycle.
- R3: The parity byte (position 2) is the bitwise XOR of all 537 bytes output in the previous frame. In the first frame after reset it is 0x00.
- R4: In the maintenance byte (position 4), bit 7 is the defect bit from `rdi_in`, bit 6 is the error-indication bit from `rei_in`, and bits 5:0 are `ma_spare`.
- R5: `err_req[0]` makes the next internally generated alignment byte 1 equal 0x76 (bit 7 inverted). `err_done[0]` pulses with that byte.
- R6: `err_req[1]` inverts bit 0 of the next internally computed parity byte. `err_done[1]` pulses with that byte.
- R7: `err_req[2]` inverts the next defect bit, so 1 is sent where `rdi_in` is 0 and 0 is sent where it is 1. `err_done[2]` pulses with the maintenance byte.
- R8: `err_req[3]` inverts the next error-indication bit relative to `rei_in`. `err_done[3]` pulses with the maintenance byte.
- R9: `oh_src_ext` has bit 0 for both alignment bytes, bit 1 for parity, bit 2 for the defect bit and bit 3 for the error-indication bit. When a bit is 1, the field takes `ext_oh_byte`, `ext_rdi` or `ext_rei`. A pending request for that field is then dropped at the field's position, with no inversion and no strobe, and the following frame is error free.
- R10: A request is held until the field's next position and is applied once. A request that arrives in the cycle that forms the field's byte applies in the following frame.
- R11: During reset and in the cycle after it, `tx_byte` = 0, `tx_sof` = 0, `err_done` = 0 and `pl_ready` = 0, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_data | input | 8 | Payload byte, taken when pl_ready is high |
| pl_ready | output | 1 | The current cycle forms a payload position |
| tr_byte | input | 8 | Value for overhead position 3 |
| nr_byte | input | 8 | Value for overhead position 5 |
| gc_byte | input | 8 | Value for overhead position 6 |
| ma_spare | input | 6 | Bits 5:0 of the maintenance byte |
| rdi_in | input | 1 | Remote defect indication to send |
| rei_in | input | 1 | Remote error indication to send |
| oh_src_ext | input | 4 | Per-field external source select (see R9) |
| ext_oh_byte | input | 8 | External alignment or parity byte |
| ext_rdi | input | 1 | External defect bit |
| ext_rei | input | 1 | External error-indication bit |
| err_req | input | 4 | Single-cycle error requests (see R5 to R8) |
| tx_byte | output | 8 | Transmitted frame byte |
| tx_sof | output | 1 | High with alignment byte 1 |
| err_done | output | 4 | Strobe per applied error, aligned with the corrupted byte |

## Verification
The hardest case to produce is a request that lands in the very cycle that consumes it. The bench finds that cycle by watching `pl_ready` fall at the end of the payload, which is the cycle that forms alignment byte 1. It pulses the alignment request there and expects a clean alignment byte in the frame that follows, then a corrupted one a frame later. A second hard case is a request that is dropped under an external source. For this, a frame with every field external and every request raised is followed by an internal frame with no request, and that frame must come out clean.

// File: rtl/e3oh_pkg.sv
`timescale 1ns/1ps
package e3oh_pkg;

    localparam int BYTE_W    = 8;
    localparam int FRAME_LEN = 537;
    localparam int OH_LEN    = 7;

    localparam logic [BYTE_W-1:0] ALIGN1_PAT = 8'hF6;
    localparam logic [BYTE_W-1:0] ALIGN2_PAT = 8'h28;
    localparam logic [BYTE_W-1:0] ALIGN_FLIP = 8'h80;
    localparam logic [BYTE_W-1:0] PARITY_FLIP = 8'h01;

    typedef enum logic [2:0] {
        SLOT_AL1   = 3'd0,
        SLOT_AL2   = 3'd1,
        SLOT_PAR   = 3'd2,
        SLOT_TRC   = 3'd3,
        SLOT_MAINT = 3'd4,
        SLOT_NET   = 3'd5,
        SLOT_GEN   = 3'd6,
        SLOT_PAY   = 3'd7
    } slot_e;

    // bit 0 alignment, bit 1 parity, bit 2 defect, bit 3 error indication
    typedef struct packed {
        logic rei;
        logic rdi;
        logic par;
        logic al;
    } oh_flags_t;

    function automatic slot_e slot_of(input logic [15:0] p);
        slot_e s;
        case (p)
            16'd0:   s = SLOT_AL1;
            16'd1:   s = SLOT_AL2;
            16'd2:   s = SLOT_PAR;
            16'd3:   s = SLOT_TRC;
            16'd4:   s = SLOT_MAINT;
            16'd5:   s = SLOT_NET;
            16'd6:   s = SLOT_GEN;
            default: s = SLOT_PAY;
        endcase
        return s;
    endfunction

    function automatic oh_flags_t consume_mask(input slot_e s);
        oh_flags_t m;
        m     = '0;
        m.al  = (s == SLOT_AL1);
        m.par = (s == SLOT_PAR);
        m.rdi = (s == SLOT_MAINT);
        m.rei = (s == SLOT_MAINT);
        return m;
    endfunction

endpackage

// File: rtl/e3oh_frame_ctr.sv
`timescale 1ns/1ps
module e3oh_frame_ctr
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = e3oh_pkg::FRAME_LEN,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  frame_end
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_q == LAST_POS) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign slot      = slot_of(16'(pos_q));
    assign frame_end = (pos_q == LAST_POS);

endmodule

// File: rtl/e3oh_err_ctl.sv
`timescale 1ns/1ps
module e3oh_err_ctl
    import e3oh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  oh_flags_t req,
    input  oh_flags_t ext_sel,
    input  slot_e     slot,
    output oh_flags_t apply
);
    localparam int NFLD = $bits(oh_flags_t);

    logic [NFLD-1:0] pend_q;
    logic [NFLD-1:0] use_now;
    logic [NFLD-1:0] req_v;
    logic [NFLD-1:0] ext_v;
    logic [NFLD-1:0] apply_v;

    assign use_now = consume_mask(slot);
    assign req_v   = req;
    assign ext_v   = ext_sel;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[g] <= 1'b0;
            end else begin
                // a request seen in the consuming cycle survives into the next frame
                pend_q[g] <= (pend_q[g] & ~use_now[g]) | req_v[g];
            end
        end
        assign apply_v[g] = pend_q[g] & use_now[g] & ~ext_v[g];
    end

    assign apply = apply_v;

endmodule

// File: rtl/e3oh_bip8.sv
`timescale 1ns/1ps
module e3oh_bip8 #(
    parameter int W = e3oh_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_end,
    input  logic [W-1:0] next_byte,
    output logic [W-1:0] prev_parity
);
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_d;

    assign acc_d = acc_q ^ next_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            prev_parity <= '0;
        end else if (frame_end) begin
            acc_q       <= '0;
            prev_parity <= acc_d;
        end else begin
            acc_q       <= acc_d;
        end
    end

endmodule

// File: rtl/e3oh_byte_mux.sv
`timescale 1ns/1ps
module e3oh_byte_mux
    import e3oh_pkg::*;
#(
    parameter int W = e3oh_pkg::BYTE_W
) (
    input  slot_e        slot,
    input  oh_flags_t    apply,
    input  oh_flags_t    ext_sel,
    input  logic [W-1:0] pl_data,
    input  logic [W-1:0] tr_byte,
    input  logic [W-1:0] nr_byte,
    input  logic [W-1:0] gc_byte,
    input  logic [W-3:0] ma_spare,
    input  logic         rdi_in,
    input  logic         rei_in,
    input  logic [W-1:0] ext_oh_byte,
    input  logic         ext_rdi,
    input  logic         ext_rei,
    input  logic [W-1:0] parity,
    output logic [W-1:0] next_byte
);
    logic [W-1:0] al1_b;
    logic [W-1:0] al2_b;
    logic [W-1:0] par_b;
    logic         rdi_b;
    logic         rei_b;

    always_comb begin
        al1_b = ext_sel.al  ? ext_oh_byte : (ALIGN1_PAT ^ (apply.al ? ALIGN_FLIP : '0));
        al2_b = ext_sel.al  ? ext_oh_byte : ALIGN2_PAT;
        par_b = ext_sel.par ? ext_oh_byte : (parity ^ (apply.par ? PARITY_FLIP : '0));
        rdi_b = ext_sel.rdi ? ext_rdi : (rdi_in ^ apply.rdi);
        rei_b = ext_sel.rei ? ext_rei : (rei_in ^ apply.rei);
    end

    always_comb begin
        unique case (slot)
            SLOT_AL1:   next_byte = al1_b;
            SLOT_AL2:   next_byte = al2_b;
            SLOT_PAR:   next_byte = par_b;
            SLOT_TRC:   next_byte = tr_byte;
            SLOT_MAINT: next_byte = {rdi_b, rei_b, ma_spare};
            SLOT_NET:   next_byte = nr_byte;
            SLOT_GEN:   next_byte = gc_byte;
            default:    next_byte = pl_data;
        endcase
    end

endmodule

// File: rtl/e3oh_gen.sv
`timescale 1ns/1ps
module e3oh_gen
    import e3oh_pkg::*;
#(
    parameter int FRAME_LEN = e3oh_pkg::FRAME_LEN,
    parameter int W         = e3oh_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pl_data,
    output logic         pl_ready,
    input  logic [W-1:0] tr_byte,
    input  logic [W-1:0] nr_byte,
    input  logic [W-1:0] gc_byte,
    input  logic [W-3:0] ma_spare,
    input  logic         rdi_in,
    input  logic         rei_in,
    input  logic [3:0]   oh_src_ext,
    input  logic [W-1:0] ext_oh_byte,
    input  logic         ext_rdi,
    input  logic         ext_rei,
    input  logic [3:0]   err_req,
    output logic [W-1:0] tx_byte,
    output logic         tx_sof,
    output logic [3:0]   err_done
);
    slot_e        slot;
    logic         frame_end;
    oh_flags_t    req_f;
    oh_flags_t    ext_f;
    oh_flags_t    apply_f;
    logic [W-1:0] parity;
    logic [W-1:0] next_byte;

    assign req_f = err_req;
    assign ext_f = oh_src_ext;

    e3oh_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .frame_end (frame_end)
    );

    e3oh_err_ctl u_err (
        .clk     (clk),
        .rst     (rst),
        .req     (req_f),
        .ext_sel (ext_f),
        .slot    (slot),
        .apply   (apply_f)
    );

    e3oh_byte_mux #(.W(W)) u_mux (
        .slot        (slot),
        .apply       (apply_f),
        .ext_sel     (ext_f),
        .pl_data     (pl_data),
        .tr_byte     (tr_byte),
        .nr_byte     (nr_byte),
        .gc_byte     (gc_byte),
        .ma_spare    (ma_spare),
        .rdi_in      (rdi_in),
        .rei_in      (rei_in),
        .ext_oh_byte (ext_oh_byte),
        .ext_rdi     (ext_rdi),
        .ext_rei     (ext_rei),
        .parity      (parity),
        .next_byte   (next_byte)
    );

    e3oh_bip8 #(.W(W)) u_bip (
        .clk         (clk),
        .rst         (rst),
        .frame_end   (frame_end),
        .next_byte   (next_byte),
        .prev_parity (parity)
    );

    assign pl_ready = (slot == SLOT_PAY) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte  <= '0;
            tx_sof   <= 1'b0;
            err_done <= '0;
        end else begin
            tx_byte  <= next_byte;
            tx_sof   <= (slot == SLOT_AL1);
            err_done <= apply_f;
        end
    end

endmodule

// File: rtl/e3oh_gen_chk.sv
`timescale 1ns/1ps
module e3oh_gen_chk #(
    parameter int FRAME_LEN = 537
) (
    input logic       clk,
    input logic       rst,
    input logic       pl_ready,
    input logic [3:0] oh_src_ext,
    input logic [3:0] err_req,
    input logic [7:0] tx_byte,
    input logic       tx_sof,
    input logic [3:0] err_done
);
    logic [15:0] since_sof;
    logic [3:0]  seen_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_sof <= '0;
            seen_req  <= '0;
        end else begin
            if (tx_sof) since_sof <= 16'd1;
            else if (since_sof != 0) since_sof <= since_sof + 16'd1;
            seen_req <= (seen_req & ~err_done) | err_req;
        end
    end

    AST_SOF_SPACING: assert property (@(posedge clk) disable iff (rst)
        (since_sof != 0) |-> (tx_sof == (since_sof == 16'(FRAME_LEN)))); // R1
    AST_ALIGN2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        tx_sof |=> (tx_byte == 8'h28 || $past(oh_src_ext[0]))); // R1
    AST_NO_READY_BEFORE_SOF: assert property (@(posedge clk) disable iff (rst)
        tx_sof |-> !$past(pl_ready)); // R2
    AST_ALIGN_ERR_VALUE: assert property (@(posedge clk) disable iff (rst)
        err_done[0] |-> (tx_sof && tx_byte == 8'h76)); // R5
    AST_PAR_ERR_SLOT: assert property (@(posedge clk) disable iff (rst)
        err_done[1] |-> $past(tx_sof, 2)); // R6
    AST_RDI_ERR_SLOT: assert property (@(posedge clk) disable iff (rst)
        err_done[2] |-> $past(tx_sof, 4)); // R7
    AST_REI_ERR_SLOT: assert property (@(posedge clk) disable iff (rst)
        err_done[3] |-> $past(tx_sof, 4)); // R8
    AST_EXT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (err_done & $past(oh_src_ext)) == 4'b0000); // R9
    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (err_done & ~seen_req) == 4'b0000); // R10

endmodule

bind e3oh_gen e3oh_gen_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pl_ready   (pl_ready),
    .oh_src_ext (oh_src_ext),
    .err_req    (err_req),
    .tx_byte    (tx_byte),
    .tx_sof     (tx_sof),
    .err_done   (err_done)
);

// File: tb/e3oh_gen_bench.sv
`timescale 1ns/1ps
module e3oh_gen_bench;

    localparam int FLEN = 537;
    localparam int NVEC = 9;
    localparam logic [7:0] TRV = 8'h3C;
    localparam logic [7:0] NRV = 8'h5A;
    localparam logic [7:0] GCV = 8'hC3;
    localparam logic [5:0] MSV = 6'h2B;

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] ext;
        logic       rdi;
        logic       rei;
        logic       xrdi;
        logic       xrei;
        logic [7:0] xbyte;
        logic [7:0] exp_al1;
        logic [1:0] exp_ma;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF6, 2'b00},
        '{4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h76, 2'b00},
        '{4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF6, 2'b00},
        '{4'b0100, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF6, 2'b10},
        '{4'b1100, 4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hF6, 2'b00},
        '{4'b1111, 4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'hA5, 2'b10},
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'hF6, 2'b10},
        '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF6, 2'b01},
        '{4'b1111, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h76, 2'b10}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pl_data = 8'h00;
    logic       pl_ready;
    logic       rdi_in = 1'b0;
    logic       rei_in = 1'b0;
    logic [3:0] oh_src_ext = 4'b0000;
    logic [7:0] ext_oh_byte = 8'h00;
    logic       ext_rdi = 1'b0;
    logic       ext_rei = 1'b0;
    logic [3:0] err_req = 4'b0000;
    logic [7:0] tx_byte;
    logic       tx_sof;
    logic [3:0] err_done;

    always #5 clk = ~clk;

    e3oh_gen u_e3oh_gen (
        .clk(clk), .rst(rst), .pl_data(pl_data), .pl_ready(pl_ready),
        .tr_byte(TRV), .nr_byte(NRV), .gc_byte(GCV), .ma_spare(MSV),
        .rdi_in(rdi_in), .rei_in(rei_in), .oh_src_ext(oh_src_ext),
        .ext_oh_byte(ext_oh_byte), .ext_rdi(ext_rdi), .ext_rei(ext_rei),
        .err_req(err_req), .tx_byte(tx_byte), .tx_sof(tx_sof), .err_done(err_done)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] cap [FLEN];
    logic [7:0] lfsr = 8'h1D;
    int   done_cnt [4];
    int   pay_bad;
    int   rdy_bad;
    bit   stim_on = 1'b0;
    vec_t stim;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] xor_of_cap();
        logic [7:0] x = 8'h00;
        for (int k = 0; k < FLEN; k++) x ^= cap[k];
        return x;
    endfunction

    // precondition: tx_sof is high at the current sample point
    task automatic capture();
        logic       rdy_prev;
        logic [7:0] dat_prev;
        for (int b = 0; b < 4; b++) done_cnt[b] = 0;
        pay_bad = 0;
        rdy_bad = 0;
        cap[0] = tx_byte;
        for (int b = 0; b < 4; b++) done_cnt[b] += int'(err_done[b]);
        for (int i = 1; i < FLEN; i++) begin
            if (stim_on && i == 100) begin
                err_req     = stim.req;
                oh_src_ext  = stim.ext;
                rdi_in      = stim.rdi;
                rei_in      = stim.rei;
                ext_rdi     = stim.xrdi;
                ext_rei     = stim.xrei;
                ext_oh_byte = stim.xbyte;
            end else begin
                err_req = 4'b0000;
            end
            lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            pl_data = lfsr;
            rdy_prev = pl_ready;
            dat_prev = pl_data;
            if (rdy_prev != (i >= 7)) rdy_bad++;
            tick();
            cap[i] = tx_byte;
            if (rdy_prev && tx_byte != dat_prev) pay_bad++;
            for (int b = 0; b < 4; b++) done_cnt[b] += int'(err_done[b]);
        end
        err_req = 4'b0000;
    endtask

    task automatic seek_sof();
        int guard = 0;
        do begin
            tick();
            guard++;
        end while (!tx_sof && guard < 2 * FLEN);
        chk(tx_sof == 1'b1, "R1 frame start found", 32'(tx_sof), 32'd1);
    endtask

    task automatic check_frame(input vec_t v, input logic [7:0] prev_xor, input string lbl);
        logic [7:0] exp_par;
        logic [3:0] exp_done;
        exp_par  = v.ext[1] ? v.xbyte : (prev_xor ^ (v.req[1] ? 8'h01 : 8'h00));
        exp_done = v.req & ~v.ext;
        chk(cap[0] == v.exp_al1, {lbl, " R5 R9 alignment byte 1"}, 32'(cap[0]), 32'(v.exp_al1));
        chk(cap[1] == (v.ext[0] ? v.xbyte : 8'h28), {lbl, " R1 alignment byte 2"}, 32'(cap[1]),
            32'(v.ext[0] ? v.xbyte : 8'h28));
        chk(cap[2] == exp_par, {lbl, " R3 R6 parity byte"}, 32'(cap[2]), 32'(exp_par));
        chk(cap[4] == {v.exp_ma, MSV}, {lbl, " R4 R7 R8 maintenance byte"}, 32'(cap[4]),
            32'({v.exp_ma, MSV}));
        chk(cap[3] == TRV && cap[5] == NRV && cap[6] == GCV, {lbl, " R1 register bytes"},
            32'({cap[3], cap[5], cap[6]}), 32'({TRV, NRV, GCV}));
        for (int b = 0; b < 4; b++)
            chk(done_cnt[b] == int'(exp_done[b]), {lbl, " R10 strobe count"},
                32'(done_cnt[b]), 32'(exp_done[b]));
        chk(pay_bad == 0 && rdy_bad == 0, {lbl, " R2 payload and ready"},
            32'(pay_bad + rdy_bad), 32'd0);
    endtask

    initial begin : main
        logic [7:0] px;
        vec_t       quiet;
        quiet = VECS[0];

        // reset state, R11
        repeat (3) tick();
        chk(tx_byte == 8'h00 && tx_sof == 1'b0 && err_done == 4'b0000 && pl_ready == 1'b0,
            "R11 reset outputs", 32'({tx_byte, tx_sof, err_done, pl_ready}), 32'd0);
        rst = 1'b0;
        chk(pl_ready == 1'b0 && tx_sof == 1'b0, "R11 first cycle after reset",
            32'({pl_ready, tx_sof}), 32'd0);

        // first frame after reset: parity byte is zero, R3
        seek_sof();
        capture();
        chk(cap[2] == 8'h00, "R3 first frame parity", 32'(cap[2]), 32'd0);
        chk(cap[0] == 8'hF6, "R1 first alignment byte", 32'(cap[0]), 32'hF6);
        px = xor_of_cap();

        // vector table: stimulus in frame A, results in frame B
        for (int v = 0; v < NVEC; v++) begin
            stim    = VECS[v];
            stim_on = 1'b1;
            seek_sof();
            capture();
            stim_on = 1'b0;
            px = xor_of_cap();
            seek_sof();
            capture();
            check_frame(stim, px, $sformatf("vec%0d", v));
            px = xor_of_cap();
        end

        // back to all internal, no requests
        stim    = quiet;
        stim_on = 1'b1;
        seek_sof();
        capture();
        stim_on = 1'b0;
        px = xor_of_cap();

        // R10: request in the cycle that forms alignment byte 1 waits a frame
        seek_sof();
        capture();
        px = xor_of_cap();
        chk(pl_ready == 1'b0, "R2 ready low at frame end", 32'(pl_ready), 32'd0);
        err_req = 4'b0001;
        tick();
        err_req = 4'b0000;
        chk(tx_sof == 1'b1 && tx_byte == 8'hF6 && err_done == 4'b0000,
            "R10 same-cycle request not applied yet", 32'({tx_sof, tx_byte, err_done}),
            32'({1'b1, 8'hF6, 4'b0000}));
        capture();
        chk(cap[2] == px, "R3 parity after late request", 32'(cap[2]), 32'(px));
        seek_sof();
        chk(tx_byte == 8'h76 && err_done == 4'b0001, "R10 R5 late request applied next frame",
            32'({tx_byte, err_done}), 32'({8'h76, 4'b0001}));
        capture();
        seek_sof();
        chk(tx_byte == 8'hF6 && err_done == 4'b0000, "R10 request applied only once",
            32'({tx_byte, err_done}), 32'({8'hF6, 4'b0000}));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule